// File: doc/BRIEF.md
# Host Bridge Configuration Space with Shadow Attribute Decode

This block holds the byte-wide configuration space of a single-function host bridge. A simple access port carries a function number, an 8-bit register offset, a write strobe and write data. The block applies a per-offset write filter to every write. Some bytes are read-only identity values. Some bytes store a masked value with forced bits, and some store a constant no matter what is written. Read data is registered and comes back one cycle after the offset is presented.

Two of the registers also steer a shadow-memory attribute decoder. The 64 KiB window at 0xE0000 is split into four 16 KiB segments. A per-segment enable nibble and a 2-bit routing mode decide, for each segment, whether reads go to internal shadow RAM or to the external bus, and whether writes do. The decoder is combinational from the stored registers and the memory address input. The memory controller uses its two flags to route each cycle.

Top module: `hostbr_cfg`

## Requirements
- R1: An access whose function number is not 0 changes no register, and its read returns 0xFF one cycle later.
- R2: Read data for function 0 is the byte at the offset presented in the previous cycle. If a write hits that same offset in that same cycle, the read shows the value the byte held before the write.
- R3: After reset, offsets 0x00..0x03 read 0x39, 0x10, 0x06, 0x04. Offsets 0x04..0x07 read 0x07, 0x00, 0x80, 0x02. Offsets 0x08..0x0A read 0, offset 0x0B reads 0x06, offset 0x0E reads 0, and offsets 0x50..0x53 read 0xBC, 0xFB, 0xAD, 0xFE. Every other byte reads 0.
- R4: Writes to offsets 0x00..0x03, 0x08..0x0C, 0x0E and 0x10..0x4E are discarded, and those bytes keep their values.
- R5: A write to offset 0x04 stores (data & 0x42) | 0x04. A write to offset 0x05 stores data & 0x01.
- R6: Any write to offset 0x06 stores 0x00, and any write to offset 0x07 stores 0x02.
- R7: Writes to all remaining offsets (0x0D, 0x0F, 0x4F..0xFF) store the full byte.
- R8: Segment d (0..3) covers 0xE0000 + d*0x4000 up to 0xE0000 + (d+1)*0x4000 - 1. It is enabled by bit (d+4) of the byte at offset 0x54.
- R9: For an enabled segment, bits [6:5] of offset 0x53 select the routing. 00 gives read external and write internal. 01 gives both external. 10 gives both internal. 11 gives read internal and write external.
- R10: A disabled segment, and any address outside 0xE0000..0xEFFFF, reports external routing for both reads and writes. The internal flags are 0.
- R11: The shadow flags follow the address input in the same cycle. A write to offset 0x53 or 0x54 changes them right after the clock edge that performs the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_func | input | 3 | Function number of the access |
| cfg_off | input | 8 | Register offset |
| cfg_we | input | 1 | Write strobe |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Registered read data |
| mem_addr | input | 20 | Memory address to classify |
| shd_rd_int | output | 1 | 1: read at mem_addr goes to internal shadow RAM |
| shd_wr_int | output | 1 | 1: write at mem_addr goes to internal shadow RAM |

## Verification
Two things can land on the same clock edge: a configuration write and the registered read, and a write to the shadow control bytes and the attribute lookup on the address bus. The bench writes a byte while it reads the same offset. It expects the old value at that edge and the new value on the next read. It also holds a window address steady while it writes offset 0x54. The flags are judged just before the edge, where they must still be external, and just after it, where they must show the new routing. The read data returned at that same edge must still show the old 0x54 contents.

// File: rtl/hostbr_pkg.sv
package hostbr_pkg;

   typedef enum logic [1:0] {
      SHM_RX_WI = 2'b00,
      SHM_RX_WX = 2'b01,
      SHM_RI_WI = 2'b10,
      SHM_RI_WX = 2'b11
   } shd_mode_e;

   localparam logic [7:0] OFF_CMD_LO  = 8'h04;
   localparam logic [7:0] OFF_CMD_HI  = 8'h05;
   localparam logic [7:0] OFF_STS_LO  = 8'h06;
   localparam logic [7:0] OFF_STS_HI  = 8'h07;
   localparam logic [7:0] OFF_SHD_MOD = 8'h53;
   localparam logic [7:0] OFF_SHD_EN  = 8'h54;

   typedef struct packed {
      logic       keep;
      logic [7:0] val;
   } wfilt_t;

   function automatic logic [7:0] cfg_reset_byte(input logic [7:0] off);
      logic [7:0] v;
      case (off)
         8'h00:   v = 8'h39;
         8'h01:   v = 8'h10;
         8'h02:   v = 8'h06;
         8'h03:   v = 8'h04;
         8'h04:   v = 8'h07;
         8'h06:   v = 8'h80;
         8'h07:   v = 8'h02;
         8'h0B:   v = 8'h06;
         8'h50:   v = 8'hBC;
         8'h51:   v = 8'hFB;
         8'h52:   v = 8'hAD;
         8'h53:   v = 8'hFE;
         default: v = 8'h00;
      endcase
      return v;
   endfunction

   function automatic wfilt_t cfg_wfilter(input logic [7:0] off, input logic [7:0] d);
      wfilt_t r;
      r.keep = 1'b1;
      r.val  = d;
      if ((off >= 8'h10) && (off <= 8'h4E)) begin
         r.keep = 1'b0;
      end else begin
         case (off)
            8'h00, 8'h01, 8'h02, 8'h03,
            8'h08, 8'h09, 8'h0A, 8'h0B,
            8'h0C, 8'h0E:  r.keep = 1'b0;
            OFF_CMD_LO:    r.val  = (d & 8'h42) | 8'h04;
            OFF_CMD_HI:    r.val  = d & 8'h01;
            OFF_STS_LO:    r.val  = 8'h00;
            OFF_STS_HI:    r.val  = 8'h02;
            default:       r.val  = d;
         endcase
      end
      return r;
   endfunction

endpackage

// File: rtl/hostbr_wfilt.sv
module hostbr_wfilt
   import hostbr_pkg::*;
#(
   parameter int OFF_W = 8,
   parameter int DW    = 8
) (
   input  logic [OFF_W-1:0] off,
   input  logic [DW-1:0]    wdata,
   output logic             keep,
   output logic [DW-1:0]    wval
);
   generate
      if (OFF_W != 8 || DW != 8) begin : g_bad
         $fatal(1, "hostbr_wfilt: offset and data must be 8 bits");
      end
   endgenerate

   wfilt_t f;

   always_comb begin
      f    = cfg_wfilter(off, wdata);
      keep = f.keep;
      wval = f.val;
   end
endmodule

// File: rtl/hostbr_regfile.sv
module hostbr_regfile
   import hostbr_pkg::*;
#(
   parameter int FN_W    = 3,
   parameter int OFF_W   = 8,
   parameter int DW      = 8,
   parameter int SEG_CNT = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FN_W-1:0]    func,
   input  logic [OFF_W-1:0]   off,
   input  logic               we,
   input  logic               wkeep,
   input  logic [DW-1:0]      wval,
   output logic [DW-1:0]      rdata,
   output logic [1:0]         shd_mode,
   output logic [SEG_CNT-1:0] shd_en
);
   localparam int NBYTES  = 1 << OFF_W;
   localparam int EN_LSB  = 4;
   localparam logic [DW-1:0] ABSENT = {DW{1'b1}};

   generate
      if (EN_LSB + SEG_CNT > DW) begin : g_bad
         $fatal(1, "hostbr_regfile: enable nibble does not fit");
      end
   endgenerate

   logic [DW-1:0] cfg_q [NBYTES];
   logic          fn0;

   assign fn0 = (func == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NBYTES; i++) begin
            cfg_q[i] <= cfg_reset_byte(8'(i));
         end
         rdata <= '0;
      end else begin
         rdata <= fn0 ? cfg_q[off] : ABSENT;
         if (we && fn0 && wkeep) begin
            cfg_q[off] <= wval;
         end
      end
   end

   always_comb begin
      shd_mode = cfg_q[OFF_SHD_MOD][6:5];
      shd_en   = cfg_q[OFF_SHD_EN][EN_LSB +: SEG_CNT];
   end
endmodule

// File: rtl/hostbr_shdec.sv
module hostbr_shdec
   import hostbr_pkg::*;
#(
   parameter int              MA_W     = 20,
   parameter int              SEG_CNT  = 4,
   parameter logic [MA_W-1:0] WIN_BASE = 20'hE0000,
   parameter int              SEG_SIZE = 32'h4000
) (
   input  logic [MA_W-1:0]    addr,
   input  logic [1:0]         mode,
   input  logic [SEG_CNT-1:0] en,
   output logic               rd_int,
   output logic               wr_int
);
   localparam int WIN_END = int'(WIN_BASE) + SEG_CNT * SEG_SIZE;

   generate
      if (WIN_END > (1 << MA_W)) begin : g_bad
         $fatal(1, "hostbr_shdec: window exceeds address space");
      end
   endgenerate

   shd_mode_e     mode_e;
   logic [SEG_CNT-1:0] seg_rd;
   logic [SEG_CNT-1:0] seg_wr;

   assign mode_e = shd_mode_e'(mode);

   genvar d;
   generate
      for (d = 0; d < SEG_CNT; d++) begin : g_seg
         localparam logic [MA_W:0] LO = (MA_W+1)'(int'(WIN_BASE) + d * SEG_SIZE);
         localparam logic [MA_W:0] HI = (MA_W+1)'(int'(WIN_BASE) + (d + 1) * SEG_SIZE);
         logic hit;
         assign hit = ({1'b0, addr} >= LO) && ({1'b0, addr} < HI) && en[d];
         always_comb begin
            seg_rd[d] = 1'b0;
            seg_wr[d] = 1'b0;
            if (hit) begin
               case (mode_e)
                  SHM_RX_WI: seg_wr[d] = 1'b1;
                  SHM_RX_WX: ;
                  SHM_RI_WI: begin seg_rd[d] = 1'b1; seg_wr[d] = 1'b1; end
                  SHM_RI_WX: seg_rd[d] = 1'b1;
                  default:   ;
               endcase
            end
         end
      end
   endgenerate

   assign rd_int = |seg_rd;
   assign wr_int = |seg_wr;
endmodule

// File: rtl/hostbr_cfg.sv
module hostbr_cfg
   import hostbr_pkg::*;
#(
   parameter int              FN_W     = 3,
   parameter int              OFF_W    = 8,
   parameter int              DW       = 8,
   parameter int              MA_W     = 20,
   parameter int              SEG_CNT  = 4,
   parameter logic [MA_W-1:0] WIN_BASE = 20'hE0000,
   parameter int              SEG_SIZE = 32'h4000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [FN_W-1:0]  cfg_func,
   input  logic [OFF_W-1:0] cfg_off,
   input  logic             cfg_we,
   input  logic [DW-1:0]    cfg_wdata,
   output logic [DW-1:0]    cfg_rdata,
   input  logic [MA_W-1:0]  mem_addr,
   output logic             shd_rd_int,
   output logic             shd_wr_int
);
   logic               wkeep;
   logic [DW-1:0]      wval;
   logic [1:0]         shd_mode;
   logic [SEG_CNT-1:0] shd_en;

   hostbr_wfilt #(.OFF_W(OFF_W), .DW(DW)) u_wfilt (
      .off   (cfg_off),
      .wdata (cfg_wdata),
      .keep  (wkeep),
      .wval  (wval)
   );

   hostbr_regfile #(.FN_W(FN_W), .OFF_W(OFF_W), .DW(DW), .SEG_CNT(SEG_CNT)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .func     (cfg_func),
      .off      (cfg_off),
      .we       (cfg_we),
      .wkeep    (wkeep),
      .wval     (wval),
      .rdata    (cfg_rdata),
      .shd_mode (shd_mode),
      .shd_en   (shd_en)
   );

   hostbr_shdec #(.MA_W(MA_W), .SEG_CNT(SEG_CNT), .WIN_BASE(WIN_BASE),
                  .SEG_SIZE(SEG_SIZE)) u_shdec (
      .addr   (mem_addr),
      .mode   (shd_mode),
      .en     (shd_en),
      .rd_int (shd_rd_int),
      .wr_int (shd_wr_int)
   );
endmodule

// File: rtl/hostbr_cfg_chk.sv
module hostbr_cfg_chk #(
   parameter int FN_W    = 3,
   parameter int OFF_W   = 8,
   parameter int DW      = 8,
   parameter int MA_W    = 20,
   parameter int SEG_CNT = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [FN_W-1:0]    cfg_func,
   input logic [OFF_W-1:0]   cfg_off,
   input logic [DW-1:0]      cfg_rdata,
   input logic [MA_W-1:0]    mem_addr,
   input logic               shd_rd_int,
   input logic               shd_wr_int,
   input logic [1:0]         shd_mode,
   input logic [SEG_CNT-1:0] shd_en
);
   logic       in_win;
   logic [1:0] seg;
   assign in_win = (mem_addr[19:16] == 4'hE);
   assign seg    = mem_addr[15:14];

   // R1
   func_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_func != '0) |=> (cfg_rdata == 8'hFF));

   // R4
   vid_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_func == '0 && cfg_off == 8'h00) |=> (cfg_rdata == 8'h39));

   // R6
   sts_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_func == '0 && cfg_off == 8'h07) |=> (cfg_rdata == 8'h02));

   // R10
   out_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_win) |-> (!shd_rd_int && !shd_wr_int));

   // R10
   seg_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && !shd_en[seg]) |-> (!shd_rd_int && !shd_wr_int));

   // R9
   mode_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && shd_en[seg]) |-> (shd_rd_int == shd_mode[1] && shd_wr_int == !shd_mode[0]));
endmodule

bind hostbr_cfg hostbr_cfg_chk #(.FN_W(FN_W), .OFF_W(OFF_W), .DW(DW), .MA_W(MA_W),
                                 .SEG_CNT(SEG_CNT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_func   (cfg_func),
   .cfg_off    (cfg_off),
   .cfg_rdata  (cfg_rdata),
   .mem_addr   (mem_addr),
   .shd_rd_int (shd_rd_int),
   .shd_wr_int (shd_wr_int),
   .shd_mode   (shd_mode),
   .shd_en     (shd_en)
);

// File: tb/sim_hostbr_cfg.sv
`timescale 1ns/1ps
module sim_hostbr_cfg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cfg_func = '0;
   logic [7:0]  cfg_off = '0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_wdata = '0;
   logic [7:0]  cfg_rdata;
   logic [19:0] mem_addr = '0;
   logic        shd_rd_int;
   logic        shd_wr_int;

   int checks = 0;
   int errors = 0;
   logic [7:0] rv;

   always #5 clk = ~clk;

   hostbr_cfg u0 (
      .clk(clk), .rst_n(rst_n), .cfg_func(cfg_func), .cfg_off(cfg_off),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .mem_addr(mem_addr), .shd_rd_int(shd_rd_int), .shd_wr_int(shd_wr_int)
   );

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
      end
   endtask

   task automatic rd(input logic [2:0] fn, input logic [7:0] off, output logic [7:0] v);
      @(negedge clk);
      cfg_func = fn; cfg_off = off; cfg_we = 1'b0;
      @(posedge clk); #1;
      v = cfg_rdata;
   endtask

   task automatic wr(input logic [2:0] fn, input logic [7:0] off, input logic [7:0] d);
      @(negedge clk);
      cfg_func = fn; cfg_off = off; cfg_we = 1'b1; cfg_wdata = d;
      @(posedge clk); #1;
      cfg_we = 1'b0; cfg_func = '0;
   endtask

   task automatic shd(input string tag, input logic [19:0] a, input logic er, input logic ew);
      mem_addr = a; #1;
      chk(tag, {6'b0, shd_rd_int, shd_wr_int}, {6'b0, er, ew});
   endtask

   task automatic t_reset;
      logic [7:0] exp [16] = '{8'h39,8'h10,8'h06,8'h04,8'h07,8'h00,8'h80,8'h02,
                               8'h00,8'h00,8'h00,8'h06,8'h00,8'h00,8'h00,8'h00};
      for (int i = 0; i < 16; i++) begin
         rd(3'd0, 8'(i), rv); chk("R3 identity", rv, exp[i]);
      end
      rd(3'd0, 8'h50, rv); chk("R3 50", rv, 8'hBC);
      rd(3'd0, 8'h51, rv); chk("R3 51", rv, 8'hFB);
      rd(3'd0, 8'h52, rv); chk("R3 52", rv, 8'hAD);
      rd(3'd0, 8'h53, rv); chk("R3 53", rv, 8'hFE);
      rd(3'd0, 8'h54, rv); chk("R3 54", rv, 8'h00);
      rd(3'd0, 8'hC7, rv); chk("R3 other", rv, 8'h00);
      shd("R10 reset disabled", 20'hE0000, 1'b0, 1'b0);
   endtask

   task automatic t_func;
      wr(3'd1, 8'h80, 8'h5A);
      rd(3'd0, 8'h80, rv); chk("R1 write ignored", rv, 8'h00);
      rd(3'd3, 8'h80, rv); chk("R1 read FF", rv, 8'hFF);
      rd(3'd7, 8'h00, rv); chk("R1 read FF id", rv, 8'hFF);
   endtask

   task automatic t_ro;
      wr(3'd0, 8'h00, 8'hFF); rd(3'd0, 8'h00, rv); chk("R4 00", rv, 8'h39);
      wr(3'd0, 8'h0B, 8'hFF); rd(3'd0, 8'h0B, rv); chk("R4 0B", rv, 8'h06);
      wr(3'd0, 8'h0C, 8'hFF); rd(3'd0, 8'h0C, rv); chk("R4 0C", rv, 8'h00);
      wr(3'd0, 8'h0E, 8'hFF); rd(3'd0, 8'h0E, rv); chk("R4 0E", rv, 8'h00);
      wr(3'd0, 8'h10, 8'hFF); rd(3'd0, 8'h10, rv); chk("R4 10", rv, 8'h00);
      wr(3'd0, 8'h4E, 8'hFF); rd(3'd0, 8'h4E, rv); chk("R4 4E", rv, 8'h00);
      wr(3'd0, 8'h4F, 8'h11); rd(3'd0, 8'h4F, rv); chk("R7 4F", rv, 8'h11);
      wr(3'd0, 8'h0D, 8'h22); rd(3'd0, 8'h0D, rv); chk("R7 0D", rv, 8'h22);
      wr(3'd0, 8'h0F, 8'h33); rd(3'd0, 8'h0F, rv); chk("R7 0F", rv, 8'h33);
      wr(3'd0, 8'hFF, 8'hC3); rd(3'd0, 8'hFF, rv); chk("R7 FF", rv, 8'hC3);
   endtask

   task automatic t_cmd;
      wr(3'd0, 8'h04, 8'hFF); rd(3'd0, 8'h04, rv); chk("R5 cmd FF", rv, 8'h46);
      wr(3'd0, 8'h04, 8'h00); rd(3'd0, 8'h04, rv); chk("R5 cmd 00", rv, 8'h04);
      wr(3'd0, 8'h05, 8'hFF); rd(3'd0, 8'h05, rv); chk("R5 05", rv, 8'h01);
      wr(3'd0, 8'h06, 8'hFF); rd(3'd0, 8'h06, rv); chk("R6 06", rv, 8'h00);
      wr(3'd0, 8'h07, 8'h00); rd(3'd0, 8'h07, rv); chk("R6 07", rv, 8'h02);
   endtask

   task automatic t_shadow;
      wr(3'd0, 8'h54, 8'hF0);
      wr(3'd0, 8'h53, 8'h9E);
      shd("R9 mode00", 20'hE8000, 1'b0, 1'b1);
      wr(3'd0, 8'h53, 8'hBE);
      shd("R9 mode01", 20'hE8000, 1'b0, 1'b0);
      wr(3'd0, 8'h53, 8'hDE);
      shd("R9 mode10", 20'hEC000, 1'b1, 1'b1);
      wr(3'd0, 8'h53, 8'hFE);
      shd("R9 mode11", 20'hE0000, 1'b1, 1'b0);
      wr(3'd0, 8'h53, 8'hDE);
      wr(3'd0, 8'h54, 8'h50);
      shd("R8 seg0 last", 20'hE3FFF, 1'b1, 1'b1);
      shd("R8 seg1 first", 20'hE4000, 1'b0, 1'b0);
      shd("R8 seg2", 20'hE8123, 1'b1, 1'b1);
      shd("R8 seg3 last", 20'hEFFFF, 1'b0, 1'b0);
      wr(3'd0, 8'h54, 8'hFF);
      shd("R10 below", 20'hDFFFF, 1'b0, 1'b0);
      shd("R10 above", 20'hF0000, 1'b0, 1'b0);
   endtask

   task automatic t_same_cycle;
      wr(3'd0, 8'h54, 8'h00);
      @(negedge clk);
      cfg_func = '0; cfg_off = 8'h60; cfg_we = 1'b1; cfg_wdata = 8'hA5;
      @(posedge clk); #1;
      cfg_we = 1'b0;
      chk("R2 old value on write edge", cfg_rdata, 8'h00);
      rd(3'd0, 8'h60, rv); chk("R2 new value next", rv, 8'hA5);
      @(negedge clk);
      mem_addr = 20'hE4000;
      cfg_off = 8'h54; cfg_we = 1'b1; cfg_wdata = 8'h20;
      #1;
      chk("R11 before edge", {6'b0, shd_rd_int, shd_wr_int}, 8'h00);
      @(posedge clk); #1;
      cfg_we = 1'b0;
      chk("R11 after edge", {6'b0, shd_rd_int, shd_wr_int}, 8'h03);
      chk("R2 54 old on edge", cfg_rdata, 8'h00);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      t_reset;
      t_func;
      t_ro;
      t_cmd;
      t_shadow;
      t_same_cycle;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      checks++; errors++;
      $display("FAIL watchdog expired got=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule